// File: doc/BRIEF.md
# Fused Bias-Activation Post-Processor

This block is a row of parallel lanes that turns wide accumulator results from a matrix-vector multiply into activated INT8 values. Each lane can add its own bias. It then scales the sum down with a programmable arithmetic right shift, rounding to nearest, and saturates the result to the signed 8-bit range. Last, it applies the selected activation. Bias add, scaling and ReLU are fused into one register stage. A second stage either passes that byte on or uses it as the index into a 256-entry programmable table that returns any 8-bit function, such as sigmoid or GELU.

One vector of `LANES` elements enters per handshake on a valid/ready stream. The result leaves two clock cycles later. A stalled output freezes the whole pipeline. A configuration strobe loads the activation mode and the shift amount. A byte-wide write port loads the table, and every lane's copy receives the same write. The intended use is to change the mode and the table only while no data is in flight.

Top module: `bias_act_pp`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. The mode is bypass and the shift is 0.
- R2: A vector accepted with `in_valid && in_ready` appears with `out_valid` high exactly two clock edges later, provided `out_ready` stays high. It is not visible one edge after acceptance.
- R3: Mode code 0 (bypass) outputs sat8(round(acc >>> shift)). The bias input is ignored.
- R4: Rounding adds 2^(shift-1) before the arithmetic right shift, so ties go toward positive infinity. A shift of 0 leaves the value unrounded. Legal shifts are 0 to ACC_W-1.
- R5: A scaled value above 127 gives 127, and a value below -128 gives -128.
- R6: Mode code 1 (ReLU) outputs max(0, sat8(round(acc >>> shift))). The bias is ignored.
- R7: Mode code 2 (fused bias+ReLU) outputs max(0, sat8(round((acc + bias) >>> shift))). This is computed in one register stage.
- R8: Mode code 3 (table) outputs table[idx]. Here idx is the two's-complement byte of sat8(round((acc + bias) >>> shift)).
- R9: A table write (`tbl_we`, `tbl_addr`, `tbl_data`) lands on the next clock edge in every lane's table. A lookup of the same address at that same edge returns the previous entry.
- R10: While `out_valid` is high and `out_ready` is low, `in_ready` is low and `out_data` is held unchanged.
- R11: Lane i uses only `in_acc[i*ACC_W +: ACC_W]` and `in_bias[i*BIAS_W +: BIAS_W]`, and it drives only `out_data[i*8 +: 8]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Load mode and shift registers |
| cfg_mode | input | 2 | Mode: 0 bypass, 1 ReLU, 2 bias+ReLU, 3 table |
| cfg_shift | input | SH_W | Right-shift amount for scaling |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 8 | Table write address |
| tbl_data | input | 8 | Table write data |
| in_valid | input | 1 | Input vector valid |
| in_ready | output | 1 | Input vector accepted when high |
| in_acc | input | LANES*ACC_W | Signed accumulator per lane |
| in_bias | input | LANES*BIAS_W | Signed bias per lane |
| out_valid | output | 1 | Output vector valid |
| out_ready | input | 1 | Downstream accepts output |
| out_data | output | LANES*8 | Signed INT8 result per lane |

## Verification
A table write and a table lookup of the same address can fall on the same clock edge. The bench provokes this by accepting a table-mode vector whose lane indexes a chosen entry. On the following cycle it strobes a write of a new value to that entry. The output must carry the old entry, and a second vector sent afterwards must carry the new one. A stall can also coincide with a fresh input offer. That case is judged by holding `out_ready` low over several cycles and requiring `in_ready` low and the output bytes frozen.

// File: rtl/bap_pkg.sv
package bap_pkg;
  typedef enum logic [1:0] {
    MODE_PASS  = 2'd0,
    MODE_RELU  = 2'd1,
    MODE_BRELU = 2'd2,
    MODE_TABLE = 2'd3
  } bap_mode_e;

  localparam int unsigned BYTE_W = 8;
endpackage

// File: rtl/bap_scale.sv
module bap_scale
  import bap_pkg::*;
#(
  parameter int unsigned ACC_W  = 24,
  parameter int unsigned BIAS_W = 16,
  parameter int unsigned SH_W   = 5
) (
  input  logic signed [ACC_W-1:0]  acc,
  input  logic signed [BIAS_W-1:0] bias,
  input  logic                     use_bias,
  input  logic                     relu,
  input  logic [SH_W-1:0]          shift,
  output logic [BYTE_W-1:0]        res
);
  localparam int unsigned SUM_W = ((ACC_W > BIAS_W) ? ACC_W : BIAS_W) + 2;
  localparam logic signed [SUM_W-1:0] MAXV = SUM_W'(127);
  localparam logic signed [SUM_W-1:0] MINV = -SUM_W'(128);

  logic signed [SUM_W-1:0] sum;
  logic signed [SUM_W-1:0] rnd;
  logic signed [SUM_W-1:0] scaled;
  logic signed [BYTE_W-1:0] sat;

  always_comb begin
    sum = SUM_W'(acc);
    if (use_bias) sum = sum + SUM_W'(bias);
    rnd = '0;
    if (shift != '0) rnd = SUM_W'(1) <<< (shift - SH_W'(1));
    scaled = (sum + rnd) >>> shift;
    if (scaled > MAXV)      sat = 8'sd127;
    else if (scaled < MINV) sat = -8'sd128;
    else                    sat = scaled[BYTE_W-1:0];
    if (relu && sat[BYTE_W-1]) sat = '0;
    res = sat;
  end
endmodule

// File: rtl/bap_lut.sv
module bap_lut #(
  parameter int unsigned IDX_W = 8,
  parameter int unsigned DAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [DAT_W-1:0] wr_data,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_addr,
  output logic [DAT_W-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [DAT_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/bias_act_pp.sv
module bias_act_pp
  import bap_pkg::*;
#(
  parameter int unsigned LANES  = 4,
  parameter int unsigned ACC_W  = 24,
  parameter int unsigned BIAS_W = 16,
  parameter int unsigned SH_W   = 5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [1:0]                cfg_mode,
  input  logic [SH_W-1:0]           cfg_shift,
  input  logic                      tbl_we,
  input  logic [7:0]                tbl_addr,
  input  logic [7:0]                tbl_data,
  input  logic                      in_valid,
  output logic                      in_ready,
  input  logic [LANES*ACC_W-1:0]    in_acc,
  input  logic [LANES*BIAS_W-1:0]   in_bias,
  output logic                      out_valid,
  input  logic                      out_ready,
  output logic [LANES*BYTE_W-1:0]   out_data
);
  localparam int unsigned VEC_W = LANES * BYTE_W;

  bap_mode_e         mode_q, mode_d, m1_q, m1_d, m2_q, m2_d;
  logic [SH_W-1:0]   shift_q, shift_d;
  logic              adv;
  logic              v1_q, v1_d, v2_q, v2_d;
  logic [VEC_W-1:0]  s1_d, s1_q, p2_q, lut_q;
  logic              use_bias, relu;

  assign adv       = !v2_q || out_ready;
  assign in_ready  = adv;
  assign out_valid = v2_q;
  assign use_bias  = (mode_q == MODE_BRELU) || (mode_q == MODE_TABLE);
  assign relu      = (mode_q == MODE_RELU)  || (mode_q == MODE_BRELU);

  always_comb begin
    mode_d  = mode_q;
    shift_d = shift_q;
    if (cfg_we) begin
      mode_d  = bap_mode_e'(cfg_mode);
      shift_d = cfg_shift;
    end
    v1_d = in_valid;
    m1_d = mode_q;
    v2_d = v1_q;
    m2_d = m1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_PASS;
      shift_q <= '0;
      v1_q    <= 1'b0;
      m1_q    <= MODE_PASS;
      s1_q    <= '0;
      v2_q    <= 1'b0;
      m2_q    <= MODE_PASS;
      p2_q    <= '0;
    end else begin
      mode_q  <= mode_d;
      shift_q <= shift_d;
      if (adv) begin
        v1_q <= v1_d;
        m1_q <= m1_d;
        s1_q <= s1_d;
        v2_q <= v2_d;
        m2_q <= m2_d;
        p2_q <= s1_q;
      end
    end
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    bap_scale #(.ACC_W(ACC_W), .BIAS_W(BIAS_W), .SH_W(SH_W)) u_scale (
      .acc      (in_acc[i*ACC_W +: ACC_W]),
      .bias     (in_bias[i*BIAS_W +: BIAS_W]),
      .use_bias (use_bias),
      .relu     (relu),
      .shift    (shift_q),
      .res      (s1_d[i*BYTE_W +: BYTE_W])
    );

    bap_lut #(.IDX_W(BYTE_W), .DAT_W(BYTE_W)) u_lut (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (tbl_we),
      .wr_addr (tbl_addr),
      .wr_data (tbl_data),
      .rd_en   (adv),
      .rd_addr (s1_q[i*BYTE_W +: BYTE_W]),
      .rd_data (lut_q[i*BYTE_W +: BYTE_W])
    );

    assign out_data[i*BYTE_W +: BYTE_W] = (m2_q == MODE_TABLE) ?
      lut_q[i*BYTE_W +: BYTE_W] : p2_q[i*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/bap_chk.sv
module bap_chk
  import bap_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic [LANES*BYTE_W-1:0] out_data,
  input logic [1:0]              stage_mode
);
  logic any_neg;
  always_comb begin
    any_neg = 1'b0;
    for (int i = 0; i < LANES; i++) any_neg = any_neg | out_data[i*BYTE_W + BYTE_W - 1];
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)); // R10

  AST_STALL_BLOCKS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R10

  AST_RELU_NONNEG: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (stage_mode == 2'd1 || stage_mode == 2'd2) |-> !any_neg); // R6 R7

  AST_FIRST_VALID_FROM_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !$past(out_valid) |-> $past(in_valid && in_ready, 2)); // R2
endmodule

bind bias_act_pp bap_chk #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .stage_mode (m2_q)
);

// File: tb/tb_bias_act_pp.sv
module tb_bias_act_pp;
  localparam int LN = 4;
  localparam int AW = 24;
  localparam int BW = 16;
  localparam int SW = 5;
  localparam int NV = 8;

  localparam int V_MODE [NV] = '{0, 0, 0, 1, 2, 2, 3, 3};
  localparam int V_SH   [NV] = '{0, 4, 2, 1, 3, 0, 2, 0};
  localparam int V_ACC  [NV][LN] = '{
    '{5, -7, 127, -128},
    '{1000, -1000, 40000, -40000},
    '{6, -6, 5, -5},
    '{-50, 50, -1, 300},
    '{-100, 100, 0, 2000},
    '{10, -10, 0, 126},
    '{400, -400, 33, -2},
    '{-128, 127, 0, -1}
  };
  localparam int V_BIAS [NV][LN] = '{
    '{100, 100, 100, 100},
    '{3, 3, 3, 3},
    '{0, 0, 0, 0},
    '{500, -500, 500, -500},
    '{200, -300, -4, 5},
    '{-11, 11, 0, 5},
    '{-20, 20, 3, 1},
    '{0, 0, 0, 0}
  };

  logic clk, rst_n;
  logic cfg_we;
  logic [1:0] cfg_mode;
  logic [SW-1:0] cfg_shift;
  logic tbl_we;
  logic [7:0] tbl_addr, tbl_data;
  logic in_valid, in_ready, out_valid, out_ready;
  logic [LN*AW-1:0] in_acc;
  logic [LN*BW-1:0] in_bias;
  logic [LN*8-1:0] out_data;

  int checks = 0;
  int errors = 0;
  logic [7:0] tbl [256];

  bias_act_pp #(.LANES(LN), .ACC_W(AW), .BIAS_W(BW), .SH_W(SW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
    .cfg_shift(cfg_shift), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_data(tbl_data), .in_valid(in_valid), .in_ready(in_ready),
    .in_acc(in_acc), .in_bias(in_bias), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_lane(input int acc, input int bias, input int mode, input int sh);
    longint s;
    s = (mode >= 2) ? longint'(acc) + longint'(bias) : longint'(acc);
    if (sh > 0) s = (s + (longint'(1) <<< (sh - 1))) >>> sh;
    if (s > 127) s = 127;
    if (s < -128) s = -128;
    if ((mode == 1 || mode == 2) && s < 0) s = 0;
    if (mode == 3) return tbl[s[7:0]];
    return s[7:0];
  endfunction

  task automatic configure(input int mode, input int sh);
    @(negedge clk);
    cfg_we = 1'b1; cfg_mode = 2'(mode); cfg_shift = SW'(sh);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_vec(input logic [LN*AW-1:0] a, input logic [LN*BW-1:0] b,
                         output logic [LN*8-1:0] res);
    @(negedge clk);
    in_valid = 1'b1; in_acc = a; in_bias = b;
    @(negedge clk);
    in_valid = 1'b0;
    check("R2 not early", 32'(out_valid), 32'd0);
    @(negedge clk);
    check("R2 valid at two", 32'(out_valid), 32'd1);
    res = out_data;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL R2 watchdog actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [LN*AW-1:0] a;
    logic [LN*BW-1:0] b;
    logic [LN*8-1:0] r, held;
    string req;

    rst_n = 1'b0; cfg_we = 1'b0; cfg_mode = '0; cfg_shift = '0;
    tbl_we = 1'b0; tbl_addr = '0; tbl_data = '0;
    in_valid = 1'b0; in_acc = '0; in_bias = '0; out_ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 out_valid", 32'(out_valid), 32'd0);
    check("R1 in_ready", 32'(in_ready), 32'd1);
    rst_n = 1'b1;

    for (int i = 0; i < 256; i++) begin
      tbl[i] = 8'((i * 37 + 11) & 255);
      @(negedge clk);
      tbl_we = 1'b1; tbl_addr = 8'(i); tbl_data = tbl[i];
    end
    @(negedge clk);
    tbl_we = 1'b0;

    // bypass / ReLU / fused / table, with ties (R4), saturation (R5), distinct lanes (R11)
    for (int k = 0; k < NV; k++) begin
      configure(V_MODE[k], V_SH[k]);
      for (int l = 0; l < LN; l++) begin
        a[l*AW +: AW] = AW'(V_ACC[k][l]);
        b[l*BW +: BW] = BW'(V_BIAS[k][l]);
      end
      run_vec(a, b, r);
      case (V_MODE[k])
        0: req = "R3 R4 R5 R11 bypass";
        1: req = "R6 R11 relu";
        2: req = "R7 R11 fused";
        default: req = "R8 R11 table";
      endcase
      for (int l = 0; l < LN; l++)
        check($sformatf("%s vec%0d lane%0d", req, k, l), 32'(r[l*8 +: 8]),
              32'(ref_lane(V_ACC[k][l], V_BIAS[k][l], V_MODE[k], V_SH[k])));
    end

    // R4 tie values written out by hand
    configure(0, 1);
    a = '0; b = '0;
    a[0 +: AW] = AW'(3); a[AW +: AW] = AW'(-3);
    run_vec(a, b, r);
    check("R4 tie +1.5", 32'(r[7:0]), 32'h02);
    check("R4 tie -1.5", 32'(r[15:8]), 32'hff);

    // R10 stall
    configure(0, 0);
    out_ready = 1'b0;
    a = '0; a[0 +: AW] = AW'(42);
    @(negedge clk); in_valid = 1'b1; in_acc = a; in_bias = '0;
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    check("R10 valid while stalled", 32'(out_valid), 32'd1);
    held = out_data;
    in_valid = 1'b1; in_acc = '1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      check("R10 in_ready low", 32'(in_ready), 32'd0);
      check("R10 data held", 32'(out_data), 32'(held));
    end
    check("R10 held value", 32'(held[7:0]), 32'd42);
    in_valid = 1'b0; out_ready = 1'b1;
    @(negedge clk);
    check("R10 released", 32'(out_valid), 32'd0);

    // R9 write and lookup of the same entry at the same edge
    configure(3, 0);
    a = '0; a[0 +: AW] = AW'(5);
    @(negedge clk); in_valid = 1'b1; in_acc = a; in_bias = '0;
    @(negedge clk); in_valid = 1'b0;
    tbl_we = 1'b1; tbl_addr = 8'd5; tbl_data = 8'hc3;
    @(negedge clk); tbl_we = 1'b0;
    check("R9 old entry on collision", 32'(out_data[7:0]), 32'(tbl[5]));
    tbl[5] = 8'hc3;
    run_vec(a, '0, r);
    check("R9 new entry after write", 32'(r[7:0]), 32'hc3);
    check("R9 other lanes", 32'(r[15:8]), 32'(tbl[0]));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule